// File: doc/BRIEF.md
# Valid-Ready Request to AXI4-Lite Master Bridge

This block takes a simple request port that carries one memory transfer at a time and turns each transfer into a single AXI4-Lite transaction. The requester raises a valid flag and holds it, together with the address, write data, byte-enable strobe and an instruction-fetch flag, until the bridge answers with a one-cycle ready. A strobe of all zeros selects a read on the address-read and read-data channels. Any other strobe selects a write on the address-write, write-data and write-response channels.

On a write both the address and data channels are raised together, and each stays raised until its own ready is seen, in whichever order the slave accepts them. The upstream transfer completes in the cycle the read data or the write response is handshaken, and the read data is passed straight through in that cycle. The fetch flag shows up only on the protection field (`3'b100` for fetches, `3'b000` for data), so a fetch with a nonzero strobe is still issued as a write.

Top module: `mem2axil_bridge`

## Requirements
- R1: While rst_ni is low, every AXI valid, bready_o, rready_o and req_ready_o are 0.
- R2: A request with req_strb_i == 0 raises arvalid_o in the cycle after the request is sampled, and leaves awvalid_o and wvalid_o low for that transfer.
- R3: A request with a nonzero req_strb_i raises awvalid_o and wvalid_o together in the cycle after the request is sampled, and leaves arvalid_o low, whatever the fetch flag.
- R4: Each of awvalid_o, wvalid_o and arvalid_o stays high until its own ready input is high at a clock edge, and is low from the next cycle on; the address and data channels are accepted independently in either order.
- R5: While a channel valid is high, awaddr_o/araddr_o equal req_addr_i, and wdata_o/wstrb_o equal req_wdata_i/req_strb_i.
- R6: awprot_o and arprot_o are 3'b100 when req_fetch_i is 1 and 3'b000 when it is 0.
- R7: bready_o is high exactly while a write is pending and rready_o exactly while a read is pending; both are low when idle.
- R8: req_ready_o is high for exactly one cycle, the cycle of the bvalid_i/bready_o or rvalid_i/rready_o handshake, and on a read req_rdata_o equals rdata_i in that cycle.
- R9: At most one AXI transaction is open: no channel valid is raised while one is pending, and after completion the next transaction starts only from a request sampled while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Upstream request valid |
| req_fetch_i | input | 1 | Request is an instruction fetch |
| req_addr_i | input | 32 | Request byte address |
| req_wdata_i | input | 32 | Write data |
| req_strb_i | input | 4 | Byte strobe; zero means read |
| req_ready_o | output | 1 | Transfer complete pulse |
| req_rdata_o | output | 32 | Read data, valid with req_ready_o |
| awvalid_o | output | 1 | Write address valid |
| awready_i | input | 1 | Write address ready |
| awaddr_o | output | 32 | Write address |
| awprot_o | output | 3 | Write protection |
| wvalid_o | output | 1 | Write data valid |
| wready_i | input | 1 | Write data ready |
| wdata_o | output | 32 | Write data |
| wstrb_o | output | 4 | Write strobe |
| bvalid_i | input | 1 | Write response valid |
| bready_o | output | 1 | Write response ready |
| arvalid_o | output | 1 | Read address valid |
| arready_i | input | 1 | Read address ready |
| araddr_o | output | 32 | Read address |
| arprot_o | output | 3 | Read protection |
| rvalid_i | input | 1 | Read data valid |
| rready_o | output | 1 | Read data ready |
| rdata_i | input | 32 | Read data |

## Verification
The assertions assume a well-behaved requester and slave: request fields stay stable while req_valid_i is high, bvalid_i only follows acceptance of both write address and data, and rvalid_i only follows acceptance of the read address, otherwise the completion checks could be hit by a stray response. The bench's slave model honours this by counting per-channel acceptance and raising a response only after every needed channel has been accepted and a random delay has passed. Requests are drawn with legal strobe values only, held unchanged until ready, and either dropped for random idle gaps or followed back-to-back by a new request.

// File: rtl/mem2axil_pkg.sv
package mem2axil_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WR   = 2'd1,
    ST_RD   = 2'd2
  } bridge_state_e;

  localparam logic [2:0] PROT_FETCH = 3'b100;
  localparam logic [2:0] PROT_DATA  = 3'b000;

  // channel slots in the valid-hold vector
  localparam int unsigned CH_AW  = 0;
  localparam int unsigned CH_W   = 1;
  localparam int unsigned CH_AR  = 2;
  localparam int unsigned N_CHAN = 3;

  function automatic logic [2:0] prot_of(input logic fetch);
    return fetch ? PROT_FETCH : PROT_DATA;
  endfunction
endpackage

// File: rtl/axil_valid_hold.sv
module axil_valid_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ready_i,
  output logic valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               valid_o <= 1'b0;
    else if (set_i)            valid_o <= 1'b1;
    else if (valid_o && ready_i) valid_o <= 1'b0;
  end

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> valid_o);
  assert_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i && !set_i) |=> !valid_o);
endmodule

// File: rtl/mem2axil_seq.sv
module mem2axil_seq
  import mem2axil_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic is_write_i,
  input  logic b_hs_i,
  input  logic r_hs_i,
  output logic start_o,
  output logic wr_pend_o,
  output logic rd_pend_o,
  output logic done_o
);
  bridge_state_e state_q, state_d;

  assign start_o   = (state_q == ST_IDLE) && req_valid_i;
  assign wr_pend_o = (state_q == ST_WR);
  assign rd_pend_o = (state_q == ST_RD);
  assign done_o    = (wr_pend_o && b_hs_i) || (rd_pend_o && r_hs_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) state_d = is_write_i ? ST_WR : ST_RD;
      ST_WR:   if (b_hs_i)      state_d = ST_IDLE;
      ST_RD:   if (r_hs_i)      state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assert_onecycle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_noreopen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_pend_o || rd_pend_o) |-> !start_o);
endmodule

// File: rtl/mem2axil_bridge.sv
module mem2axil_bridge
  import mem2axil_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned STRB_W = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_fetch_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [STRB_W-1:0] req_strb_i,
  output logic              req_ready_o,
  output logic [DATA_W-1:0] req_rdata_o,
  output logic              awvalid_o,
  input  logic              awready_i,
  output logic [ADDR_W-1:0] awaddr_o,
  output logic [2:0]        awprot_o,
  output logic              wvalid_o,
  input  logic              wready_i,
  output logic [DATA_W-1:0] wdata_o,
  output logic [STRB_W-1:0] wstrb_o,
  input  logic              bvalid_i,
  output logic              bready_o,
  output logic              arvalid_o,
  input  logic              arready_i,
  output logic [ADDR_W-1:0] araddr_o,
  output logic [2:0]        arprot_o,
  input  logic              rvalid_i,
  output logic              rready_o,
  input  logic [DATA_W-1:0] rdata_i
);
  logic is_write, start, wr_pend, rd_pend, done;
  logic [N_CHAN-1:0] ch_set, ch_rdy, ch_vld;

  assign is_write = |req_strb_i;

  mem2axil_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .is_write_i  (is_write),
    .b_hs_i      (bvalid_i),
    .r_hs_i      (rvalid_i),
    .start_o     (start),
    .wr_pend_o   (wr_pend),
    .rd_pend_o   (rd_pend),
    .done_o      (done)
  );

  assign ch_set[CH_AW] = start && is_write;
  assign ch_set[CH_W]  = start && is_write;
  assign ch_set[CH_AR] = start && !is_write;
  assign ch_rdy[CH_AW] = awready_i;
  assign ch_rdy[CH_W]  = wready_i;
  assign ch_rdy[CH_AR] = arready_i;

  for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
    axil_valid_hold u_hold (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (ch_set[c]),
      .ready_i (ch_rdy[c]),
      .valid_o (ch_vld[c])
    );
  end

  assign awvalid_o = ch_vld[CH_AW];
  assign wvalid_o  = ch_vld[CH_W];
  assign arvalid_o = ch_vld[CH_AR];

  // request fields are held stable by the requester, so pass them through
  assign awaddr_o  = req_addr_i;
  assign araddr_o  = req_addr_i;
  assign wdata_o   = req_wdata_i;
  assign wstrb_o   = req_strb_i;
  assign awprot_o  = prot_of(req_fetch_i);
  assign arprot_o  = prot_of(req_fetch_i);

  assign bready_o    = wr_pend;
  assign rready_o    = rd_pend;
  assign req_ready_o = done;
  assign req_rdata_o = rdata_i;

  always_comb begin
    if (rst_ni) begin
      assert_excl_R9: assert (!(arvalid_o && (awvalid_o || wvalid_o)));
      assert_rdyexcl_R7: assert (!(bready_o && rready_o));
    end
  end

  assert_pair_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(awvalid_o) |-> $rose(wvalid_o));
  assert_done_hs_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> ((bvalid_i && bready_o) || (rvalid_i && rready_o)));
  assert_rd_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(arvalid_o) |-> (rready_o && !awvalid_o && !wvalid_o));
endmodule

// File: tb/mem2axil_bridge_test.sv
`timescale 1ns/1ps
module mem2axil_bridge_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 0, req_fetch = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic [3:0]  req_strb = 0;
  logic        req_ready;
  logic [31:0] req_rdata;
  logic        awvalid, awready = 0, wvalid, wready = 0, bvalid = 0, bready;
  logic        arvalid, arready = 0, rvalid = 0, rready;
  logic [31:0] awaddr, araddr, wdata, rdata = 0;
  logic [3:0]  wstrb;
  logic [2:0]  awprot, arprot;

  int n_chk = 0, n_bad = 0;

  mem2axil_bridge uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_fetch_i(req_fetch), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_strb_i(req_strb),
    .req_ready_o(req_ready), .req_rdata_o(req_rdata),
    .awvalid_o(awvalid), .awready_i(awready), .awaddr_o(awaddr), .awprot_o(awprot),
    .wvalid_o(wvalid), .wready_i(wready), .wdata_o(wdata), .wstrb_o(wstrb),
    .bvalid_i(bvalid), .bready_o(bready),
    .arvalid_o(arvalid), .arready_i(arready), .araddr_o(araddr), .arprot_o(arprot),
    .rvalid_i(rvalid), .rready_o(rready), .rdata_i(rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] strb_of(input int k);
    case (k % 8)
      0: return 4'b0000; 1: return 4'b1111; 2: return 4'b1100; 3: return 4'b0011;
      4: return 4'b1000; 5: return 4'b0100; 6: return 4'b0010; default: return 4'b0001;
    endcase
  endfunction

  function automatic logic [2:0] exp_prot(input logic f);
    return f ? 3'b100 : 3'b000;
  endfunction

  task automatic check_idle();
    chk("R9 awvalid idle", {31'd0, awvalid}, 0);
    chk("R9 wvalid idle", {31'd0, wvalid}, 0);
    chk("R9 arvalid idle", {31'd0, arvalid}, 0);
    chk("R7 bready idle", {31'd0, bready}, 0);
    chk("R7 rready idle", {31'd0, rready}, 0);
    chk("R8 ready idle", {31'd0, req_ready}, 0);
  endtask

  // one transfer; called at a negedge with the previous request already gone or complete
  task automatic txn(input logic f, input logic [31:0] a, input logic [31:0] d,
                     input logic [3:0] s, input int la, input int lw, input int lr, input int lresp);
    bit wr = (s != 0);
    bit aw_done = 0, w_done = 0, ar_done = 0, fin = 0;
    logic [31:0] rd = $urandom;
    int cnt = 0;
    check_idle();
    req_valid = 1; req_fetch = f; req_addr = a; req_wdata = d; req_strb = s;
    while (!fin) begin
      @(negedge clk);
      cnt++;
      awready = 0; wready = 0; arready = 0; bvalid = 0; rvalid = 0;
      if (wr) begin
        chk("R3/R4 awvalid", {31'd0, awvalid}, {31'd0, !aw_done});
        chk("R3/R4 wvalid", {31'd0, wvalid}, {31'd0, !w_done});
        chk("R3 arvalid low on write", {31'd0, arvalid}, 0);
        chk("R7 bready pending", {31'd0, bready}, 1);
        chk("R7 rready on write", {31'd0, rready}, 0);
        if (awvalid) begin
          chk("R5 awaddr", awaddr, a);
          chk("R6 awprot", {29'd0, awprot}, {29'd0, exp_prot(f)});
        end
        if (wvalid) begin
          chk("R5 wdata", wdata, d);
          chk("R5 wstrb", {28'd0, wstrb}, {28'd0, s});
        end
        awready = (cnt > la);
        wready  = (cnt > lw);
        bvalid  = aw_done && w_done && (cnt > lresp);
      end else begin
        chk("R2/R4 arvalid", {31'd0, arvalid}, {31'd0, !ar_done});
        chk("R2 awvalid low on read", {31'd0, awvalid}, 0);
        chk("R2 wvalid low on read", {31'd0, wvalid}, 0);
        chk("R7 rready pending", {31'd0, rready}, 1);
        chk("R7 bready on read", {31'd0, bready}, 0);
        if (arvalid) begin
          chk("R5 araddr", araddr, a);
          chk("R6 arprot", {29'd0, arprot}, {29'd0, exp_prot(f)});
        end
        arready = (cnt > lr);
        rvalid  = ar_done && (cnt > lresp);
        rdata   = rd;
      end
      #1;
      if (bvalid || rvalid) begin
        chk("R8 ready on handshake", {31'd0, req_ready}, 1);
        if (!wr) chk("R8 rdata pass", req_rdata, rd);
        fin = 1;
      end else begin
        chk("R8 ready before response", {31'd0, req_ready}, 0);
      end
      if (awvalid && awready) aw_done = 1;
      if (wvalid && wready) w_done = 1;
      if (arvalid && arready) ar_done = 1;
      if (cnt > 60) begin
        chk("R8 transfer hung", 0, 1);
        fin = 1;
      end
    end
    @(negedge clk);
    awready = 0; wready = 0; arready = 0; bvalid = 0; rvalid = 0;
  endtask

  task automatic gap(input int n);
    req_valid = 0;
    req_strb = $urandom;
    for (int i = 0; i < n; i++) begin
      #1; check_idle();
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #1;
    check_idle();
    chk("R1 reset awvalid", {31'd0, awvalid}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // directed: read, write with simultaneous readies, aw before w, w before aw, fetch write
    txn(1'b1, 32'h0000_0100, 32'h0, 4'b0000, 0, 0, 0, 0);
    gap(2);
    txn(1'b0, 32'h0000_0200, 32'hdead_beef, 4'b1111, 0, 0, 0, 0);
    txn(1'b0, 32'h0000_0204, 32'h1234_5678, 4'b0011, 0, 3, 0, 1);
    gap(1);
    txn(1'b0, 32'h0000_0208, 32'hcafe_f00d, 4'b1000, 4, 1, 0, 0);
    txn(1'b1, 32'h0000_020c, 32'h0bad_c0de, 4'b0100, 2, 2, 0, 3);
    txn(1'b0, 32'h0000_0300, 32'h0, 4'b0000, 0, 0, 5, 4);
    gap(1);
    for (int k = 0; k < 150; k++) begin
      txn($urandom_range(0, 1), $urandom & 32'hffff_fffc, $urandom, strb_of($urandom_range(0, 7)),
          $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 4));
      if ($urandom_range(0, 1) == 1) gap($urandom_range(1, 3));
    end
    gap(1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule